// File: doc/BRIEF.md
# Display Scan and Scroll Controller

This block drives the refresh side of a dot-matrix graphic LCD column driver. Display RAM is organised as 64 rows of 64 bits. On every line period the block chooses which RAM row goes to the 64 segment outputs. It does this with a 6-bit line (Z) scan counter. At the line-period tick that opens a frame, the counter is loaded from a programmable start-line register. On every other tick it steps forward by one and wraps from the last row back to row 0. Writing a new start line therefore scrolls the image vertically without moving any data in RAM.

A single display-enable flag blanks or shows all segments together. When the display is off, every segment output is driven to 0 whatever the RAM holds, and RAM contents are never touched. The flag can be read back as one bit of an 8-bit status word.

The block runs on one system clock. The LCD line clock and the frame-start signal arrive as one-cycle pulses on that clock. The RAM row address is registered. Display RAM is assumed to return a row a fixed number of cycles (`RD_LAT`) after it sees an address. The segment register captures that row at a fixed delay after each line tick.

Top module: `scan_scroll_ctrl`

## Requirements
- R1: While `rst` is high at a clock edge, the display is off, the start line is 0, `row_addr_o` is 0 and `seg_o` is all zeros. All of these states are visible at the ports one cycle after the edge.
- R2: `status_o` bit 5 is 1 while the display is off and 0 while it is on. All other status bits read 0.
- R3: A `disp_we` pulse loads `disp_on_i` into the display-enable flag: 1 means on, 0 means off. While the flag is on, each segment capture loads the RAM row at the current row address into `seg_o`.
- R4: While the flag is off, each segment capture loads all zeros into `seg_o`, whatever `ram_row_i` holds.
- R5: An on/off command changes neither `row_addr_o` nor the image. Switching off and then on again brings back the same segment data for the same row.
- R6: A `line_tick` with `frame_start` high loads the start-line register into `row_addr_o` on that clock edge. If `start_we` arrives in the same cycle, the preset uses the start line held before that edge.
- R7: A `line_tick` with `frame_start` low increments `row_addr_o` by 1 on that edge, and the value wraps from 63 to 0.
- R8: A `start_we` pulse loads `start_i` into the start-line register. The new value does not alter `row_addr_o` until the next frame-start tick.
- R9: `seg_o` changes only at a segment capture. A capture happens on the clock edge `RD_LAT`+1 cycles after the `line_tick` edge. An on/off command issued between captures leaves `seg_o` unchanged until the next capture.
- R10: `row_addr_o` does not change in any cycle without a `line_tick`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| disp_we | input | 1 | On/off command strobe |
| disp_on_i | input | 1 | Value for the display-enable flag (1 = on) |
| start_we | input | 1 | Start-line command strobe |
| start_i | input | 6 | Start-line value |
| line_tick | input | 1 | One-cycle pulse per LCD line period |
| frame_start | input | 1 | Marks the line tick that opens a frame |
| ram_row_i | input | 64 | Row read from display RAM |
| row_addr_o | output | 6 | Display RAM row address (Z counter) |
| seg_o | output | 64 | Segment data |
| status_o | output | 8 | Status word, bit 5 = display off |

## Verification
The bench starts a frame at start line 62 and checks that the counter steps through 63 and then 0. A counter that saturated, or that used more bits than the row count needs, would leave the scan stuck or jump to a row that does not exist. It also writes a new start line in the same cycle as a frame-start tick. A design with the wrong priority would preset to the new value one frame early. A start-line write in mid-frame is checked to leave the running scan alone, which catches a design that reloads the counter on every register write. On the blanking side, the bench sends an off command and checks that the segments do not move until the next capture. It also samples one cycle before the capture to catch latch timing that is off by one. Finally it confirms that turning the display back on shows the original rows, which exposes any blanking scheme that corrupts the data path.

// File: rtl/scan_pkg.sv
package scan_pkg;
  // Status word layout
  localparam int STAT_W         = 8;
  localparam int STAT_BLANK_BIT = 5;

  // Build the status word from the display-enable flag
  function automatic logic [STAT_W-1:0] make_status(input logic disp_on);
    logic [STAT_W-1:0] s;
    s = '0;
    s[STAT_BLANK_BIT] = ~disp_on;
    return s;
  endfunction
endpackage

// File: rtl/scan_cfg_regs.sv
module scan_cfg_regs
  import scan_pkg::*;
#(
  parameter int ZW = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              disp_we,
  input  logic              disp_on_i,
  input  logic              start_we,
  input  logic [ZW-1:0]     start_i,
  output logic              disp_on,
  output logic [ZW-1:0]     start_line,
  output logic [STAT_W-1:0] status_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      disp_on    <= 1'b0;
      start_line <= '0;
      status_o   <= make_status(1'b0);
    end else begin
      if (disp_we) begin
        disp_on  <= disp_on_i;
        status_o <= make_status(disp_on_i);
      end
      if (start_we) start_line <= start_i;
    end
  end
endmodule

// File: rtl/scan_zcount.sv
module scan_zcount #(
  parameter int ZW = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          line_tick,
  input  logic          frame_start,
  input  logic [ZW-1:0] start_line,
  output logic [ZW-1:0] z_q
);
  localparam logic [ZW-1:0] ONE = ZW'(1);

  // The counter is as wide as the row count, so the increment wraps by itself
  always_ff @(posedge clk) begin
    if (rst)              z_q <= '0;
    else if (line_tick) begin
      if (frame_start)    z_q <= start_line;
      else                z_q <= z_q + ONE;
    end
  end
endmodule

// File: rtl/scan_seg_latch.sv
module scan_seg_latch #(
  parameter int COLS   = 64,
  parameter int RD_LAT = 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            line_tick,
  input  logic            disp_on,
  input  logic [COLS-1:0] ram_row_i,
  output logic            cap_stb,
  output logic [COLS-1:0] seg_o
);
  localparam int DLY = RD_LAT + 1;

  // Delay the tick until the row at the new address has come back from RAM
  logic [DLY-1:0] tick_d;

  generate
    if (DLY == 1) begin : g_dly_one
      always_ff @(posedge clk) begin
        if (rst) tick_d <= '0;
        else     tick_d <= line_tick;
      end
    end else begin : g_dly_chain
      always_ff @(posedge clk) begin
        if (rst) tick_d <= '0;
        else     tick_d <= {tick_d[DLY-2:0], line_tick};
      end
    end
  endgenerate

  assign cap_stb = tick_d[DLY-1];

  always_ff @(posedge clk) begin
    if (rst)          seg_o <= '0;
    else if (cap_stb) seg_o <= disp_on ? ram_row_i : '0;
  end
endmodule

// File: rtl/scan_scroll_ctrl.sv
module scan_scroll_ctrl
  import scan_pkg::*;
#(
  parameter int ZW     = 6,
  parameter int COLS   = 64,
  parameter int RD_LAT = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              disp_we,
  input  logic              disp_on_i,
  input  logic              start_we,
  input  logic [ZW-1:0]     start_i,
  input  logic              line_tick,
  input  logic              frame_start,
  input  logic [COLS-1:0]   ram_row_i,
  output logic [ZW-1:0]     row_addr_o,
  output logic [COLS-1:0]   seg_o,
  output logic [STAT_W-1:0] status_o
);
  logic          disp_on;
  logic [ZW-1:0] start_line;
  logic          cap_stb;

  scan_cfg_regs #(.ZW(ZW)) u_cfg (
    .clk        (clk),
    .rst        (rst),
    .disp_we    (disp_we),
    .disp_on_i  (disp_on_i),
    .start_we   (start_we),
    .start_i    (start_i),
    .disp_on    (disp_on),
    .start_line (start_line),
    .status_o   (status_o)
  );

  scan_zcount #(.ZW(ZW)) u_z (
    .clk         (clk),
    .rst         (rst),
    .line_tick   (line_tick),
    .frame_start (frame_start),
    .start_line  (start_line),
    .z_q         (row_addr_o)
  );

  scan_seg_latch #(.COLS(COLS), .RD_LAT(RD_LAT)) u_seg (
    .clk       (clk),
    .rst       (rst),
    .line_tick (line_tick),
    .disp_on   (disp_on),
    .ram_row_i (ram_row_i),
    .cap_stb   (cap_stb),
    .seg_o     (seg_o)
  );
endmodule

// File: rtl/scan_scroll_chk.sv
module scan_scroll_chk #(
  parameter int ZW   = 6,
  parameter int COLS = 64
) (
  input logic            clk,
  input logic            rst,
  input logic            line_tick,
  input logic            frame_start,
  input logic [ZW-1:0]   start_line,
  input logic            disp_on,
  input logic            cap_stb,
  input logic [ZW-1:0]   row_addr_o,
  input logic [COLS-1:0] seg_o,
  input logic [7:0]      status_o
);
  localparam logic [ZW-1:0] LAST = {ZW{1'b1}};

  // R1
  reset_clears_chk: assert property (@(posedge clk)
    rst |=> (seg_o == '0 && row_addr_o == '0 && status_o[5]));

  // R2
  status_one_bit_chk: assert property (@(posedge clk) disable iff (rst)
    $countones(status_o) <= 1);

  // R4
  blank_on_capture_chk: assert property (@(posedge clk) disable iff (rst)
    (cap_stb && !disp_on) |=> seg_o == '0);

  // R6
  frame_preset_chk: assert property (@(posedge clk) disable iff (rst)
    (line_tick && frame_start) |=> row_addr_o == $past(start_line));

  // R7
  wrap_to_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (line_tick && !frame_start && row_addr_o == LAST) |=> row_addr_o == '0);

  // R9
  seg_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !cap_stb |=> $stable(seg_o));

  // R10
  addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !line_tick |=> $stable(row_addr_o));
endmodule

bind scan_scroll_ctrl scan_scroll_chk #(.ZW(ZW), .COLS(COLS)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .line_tick   (line_tick),
  .frame_start (frame_start),
  .start_line  (start_line),
  .disp_on     (disp_on),
  .cap_stb     (cap_stb),
  .row_addr_o  (row_addr_o),
  .seg_o       (seg_o),
  .status_o    (status_o)
);

// File: tb/scan_scroll_ctrl_tb.sv
module scan_scroll_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        disp_we = 1'b0, disp_on_i = 1'b0;
  logic        start_we = 1'b0;
  logic [5:0]  start_i = '0;
  logic        line_tick = 1'b0, frame_start = 1'b0;
  logic [63:0] ram_q;
  logic [5:0]  row_addr_o;
  logic [63:0] seg_o;
  logic [7:0]  status_o;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  scan_scroll_ctrl u_dut (
    .clk(clk), .rst(rst), .disp_we(disp_we), .disp_on_i(disp_on_i),
    .start_we(start_we), .start_i(start_i), .line_tick(line_tick),
    .frame_start(frame_start), .ram_row_i(ram_q), .row_addr_o(row_addr_o),
    .seg_o(seg_o), .status_o(status_o)
  );

  function automatic logic [63:0] pat(input logic [5:0] r);
    logic [7:0] b;
    b = {2'b00, r} ^ 8'h5A;
    return {b, ~b, b, b ^ 8'hFF, {2'b11, r}, b, ~b, {r, 2'b01}};
  endfunction

  // RAM model with one cycle of read latency
  always_ff @(posedge clk) ram_q <= pat(row_addr_o);

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cmd_disp(input logic v);
    @(negedge clk); disp_we = 1'b1; disp_on_i = v;
    @(negedge clk); disp_we = 1'b0;
  endtask

  task automatic cmd_start(input logic [5:0] v);
    @(negedge clk); start_we = 1'b1; start_i = v;
    @(negedge clk); start_we = 1'b0;
  endtask

  // One line period; returns three negedges after the tick was driven
  task automatic do_line(input logic fs);
    @(negedge clk); line_tick = 1'b1; frame_start = fs;
    @(negedge clk); line_tick = 1'b0; frame_start = 1'b0;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset;
    rst = 1'b1;
    repeat (2) @(negedge clk);
    chk(seg_o == '0, "R1 seg", seg_o, 0);
    chk(row_addr_o == 0, "R1 addr", 64'(row_addr_o), 0);
    chk(status_o == 8'h20, "R1/R2 status off", 64'(status_o), 64'h20);
    rst = 1'b0;
    do_line(1'b1);
    chk(row_addr_o == 0, "R1 start line zero", 64'(row_addr_o), 0);
  endtask

  task automatic t_status;
    cmd_disp(1'b1);
    @(negedge clk);
    chk(status_o == 8'h00, "R2 status on", 64'(status_o), 0);
    cmd_disp(1'b0);
    @(negedge clk);
    chk(status_o == 8'h20, "R2 status off", 64'(status_o), 64'h20);
    cmd_disp(1'b1);
  endtask

  task automatic t_scan;
    cmd_start(6'd5);
    do_line(1'b1);
    chk(row_addr_o == 5, "R6 preset", 64'(row_addr_o), 5);
    chk(seg_o == pat(6'd5), "R3 seg row5", seg_o, pat(6'd5));
    for (int i = 1; i <= 3; i++) begin
      do_line(1'b0);
      chk(row_addr_o == 6'(5 + i), "R7 step", 64'(row_addr_o), 64'(5 + i));
      chk(seg_o == pat(6'(5 + i)), "R3 seg step", seg_o, pat(6'(5 + i)));
    end
  endtask

  task automatic t_wrap;
    cmd_start(6'd62);
    do_line(1'b1);
    do_line(1'b0);
    chk(row_addr_o == 63, "R7 63", 64'(row_addr_o), 63);
    do_line(1'b0);
    chk(row_addr_o == 0, "R7 wrap", 64'(row_addr_o), 0);
    chk(seg_o == pat(6'd0), "R7 seg after wrap", seg_o, pat(6'd0));
  endtask

  task automatic t_midframe;
    logic [5:0] a;
    cmd_start(6'd10);
    do_line(1'b1);
    cmd_start(6'd40);
    a = row_addr_o;
    chk(a == 10, "R8 no jump", 64'(a), 10);
    do_line(1'b0);
    chk(row_addr_o == 11, "R8 scan continues", 64'(row_addr_o), 11);
    do_line(1'b1);
    chk(row_addr_o == 40, "R8 next frame", 64'(row_addr_o), 40);
  endtask

  task automatic t_collide;
    // start line holds 40; write 20 in the same cycle as a frame tick
    @(negedge clk); line_tick = 1'b1; frame_start = 1'b1; start_we = 1'b1; start_i = 6'd20;
    @(negedge clk); line_tick = 1'b0; frame_start = 1'b0; start_we = 1'b0;
    chk(row_addr_o == 40, "R6 old start used", 64'(row_addr_o), 40);
    repeat (2) @(negedge clk);
    do_line(1'b1);
    chk(row_addr_o == 20, "R6 new start next frame", 64'(row_addr_o), 20);
  endtask

  task automatic t_blank;
    logic [5:0]  a;
    logic [63:0] held;
    held = seg_o;
    a = row_addr_o;
    cmd_disp(1'b0);
    repeat (3) @(negedge clk);
    chk(seg_o == held, "R9 no change before capture", seg_o, held);
    chk(row_addr_o == a, "R5/R10 addr untouched", 64'(row_addr_o), 64'(a));
    @(negedge clk); line_tick = 1'b1;
    @(negedge clk); line_tick = 1'b0;
    @(negedge clk);
    chk(seg_o == held, "R9 one cycle before capture", seg_o, held);
    @(negedge clk);
    chk(seg_o == '0, "R4 blanked", seg_o, 0);
    do_line(1'b1);
    chk(seg_o == '0, "R4 blanked after preset", seg_o, 0);
    cmd_disp(1'b1);
    do_line(1'b1);
    chk(seg_o == pat(6'd20), "R5 image restored", seg_o, pat(6'd20));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_status();
    t_scan();
    t_wrap();
    t_midframe();
    t_collide();
    t_blank();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule